// File: doc/BRIEF.md
# Multi-channel input capture timer

This block is a 24-bit up-counting timebase shared by three capture channels. The counter is advanced by a selectable tick. The tick comes either from a prescaler on the module clock with eight ratios (1, 4, 16, 32, 64, 96, 112, 128) or from a synchronized rising edge of one of the raw capture inputs. When a channel receives a qualified edge pulse, it copies the count into its own hold register and raises its capture flag.

The counter has further controls:
- A compare register gives a compare-match flag, and the match can optionally restart the count.
- Chosen capture events can force the count to zero.
- Chosen capture events or an overflow can load the compare value into the counter.

All five flags are sticky. Software clears a flag by writing one to it. A single interrupt line is raised by any flag whose enable is set. Edge qualification, input filtering and bus decoding sit outside the block. The block sees only control levels, edge pulses and clear strobes.

Top module: `cap_timer`

## Requirements
- R1: The count is 24 bits and rises by one per tick. A tick at 0xFFFFFF gives 0 and sets flag bit 4 (overflow), unless a clear or reload takes effect in that cycle.
- R2: With `src_sel` = 0, `div_sel` codes 0 to 7 give one tick every 1, 4, 16, 32, 64, 96, 112 or 128 clocks. The prescaler is held at its start point while `run_en` is 0, so the first increment comes N clock edges after `run_en` rises.
- R3: `src_sel` values 1, 2 and 3 use a rising edge of `cap_in[0]`, `cap_in[1]` and `cap_in[2]` as the tick. The edge passes a two-flop synchronizer: a rise present before clock edge e increments the count at edge e+2, and exactly once per rise.
- R4: While `run_en` is 0 the count holds its value. Clear and reload still apply.
- R5: When `cmp_en` is 1 and the count equals `cmp_val`, flag bit 3 (compare) is set at the next edge.
- R6: When `cmp_clr_en` is also 1, that match makes the count 0 at the next edge.
- R7: When `cap_clr_en` is 1, an `edge_evt[i]` whose `clr_src_en[i]` is 1 makes the count 0 at the next edge. An event whose enable bit is 0 leaves the count unchanged.
- R8: When `rld_en` is 1, either of two causes loads `cmp_val` into the count: an `edge_evt[i]` with `rld_src_en[i]` set (i = 0..2), or an overflow with `rld_src_en[3]` set.
- R9: When several updates coincide, clear wins over reload, and reload wins over increment.
- R10: `edge_evt[i]` copies the count as it stood before that edge's update into hold slice i (`hold_flat[24*i +: 24]`) and sets flag bit i.
- R11: The flags (bits 0 to 2 capture, 3 compare, 4 overflow) stay set until a 1 is written to the same bit of `flag_w1c`. A set and a clear of the same bit in one cycle leaves it set.
- R12: `irq` is 1 exactly when some flag bit and the same bit of `irq_en` are both 1.
- R13: After synchronous reset, the count, all hold registers and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Counter advances while 1 |
| div_sel | input | 3 | Prescaler ratio code |
| src_sel | input | 2 | Tick source: 0 prescaler, 1..3 capture input 0..2 |
| cap_in | input | 3 | Raw capture input levels, used as count sources |
| edge_evt | input | 3 | Qualified edge pulses, one per channel |
| cmp_en | input | 1 | Compare function enable |
| cmp_clr_en | input | 1 | Compare match restarts the count |
| cap_clr_en | input | 1 | Capture events may clear the count |
| clr_src_en | input | 3 | Per-channel clear source enables |
| rld_en | input | 1 | Reload function enable |
| rld_src_en | input | 4 | Reload sources: bits 0..2 channels, bit 3 overflow |
| cmp_val | input | 24 | Compare and reload value |
| flag_w1c | input | 5 | Write-one-to-clear strobes, same layout as flags |
| irq_en | input | 5 | Per-flag interrupt enables |
| count | output | 24 | Current count |
| hold_flat | output | 72 | Hold registers, channel i at bits 24*i+23:24*i |
| flags | output | 5 | Sticky flags |
| irq | output | 1 | Interrupt request |

## Verification
Each kind of wrong internal state shows at the ports, and quickly:
- A wrong prescaler phase or synchronizer state shows on `count` within one prescale period.
- A wrong update priority shows on `count` in the cycle after the coinciding events.
- A hold register that samples after the update instead of before it shows a value off by one, or the cleared or reloaded value, in the cycle after the edge pulse.
- Lost or spurious flag bits show on `flags` and `irq` in the same cycle they occur.

The cycle-by-cycle model compares every output on every clock. The first divergence is therefore reported at the clock edge where it appears.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;

    localparam int MAX_RATIO = 128;
    localparam int DIV_W     = 3;

    // Counter update request, applied in the order clr > rld > inc.
    typedef struct packed {
        logic clr;
        logic rld;
        logic inc;
    } cnt_ctl_t;

    // Irregular prescale ratios selected by a 3-bit code.
    function automatic int unsigned div_ratio(input logic [DIV_W-1:0] code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 4;
            3'd2:    return 16;
            3'd3:    return 32;
            3'd4:    return 64;
            3'd5:    return 96;
            3'd6:    return 112;
            default: return 128;
        endcase
    endfunction

endpackage

// File: rtl/cap_prescaler.sv
module cap_prescaler
    import cap_timer_pkg::*;
#(
    parameter int PW = $clog2(MAX_RATIO)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);

    logic [PW-1:0] div_q;
    logic [PW-1:0] term;

    assign term = PW'(div_ratio(div_sel) - 1);
    // >= so that a ratio change to a smaller value terminates at once
    assign tick = run_en && (div_q >= term);

    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            div_q <= '0;
        end else if (div_q >= term) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // R2: the divider phase restarts whenever counting is halted
    p_phase_restart_r2: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (div_q == '0));

endmodule

// File: rtl/cap_src_sync.sv
module cap_src_sync #(
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] cap_in,
    output logic [NCH-1:0] rise
);

    logic [NCH-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= cap_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;

    // R3: one tick per rising edge, never two in a row
    p_single_tick_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((rise & $past(rise)) == '0));

endmodule

// File: rtl/cap_counter.sv
module cap_counter
    import cap_timer_pkg::*;
#(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  cnt_ctl_t      ctl,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ctl.clr) begin
            cnt_q <= '0;
        end else if (ctl.rld) begin
            cnt_q <= load_val;
        end else if (ctl.inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9, R7: clear dominates every other request
    p_clear_wins_r9: assert property (@(posedge clk) disable iff (rst)
        ctl.clr |=> (cnt_q == '0));

    // R8: reload takes the compare value when no clear competes
    p_reload_val_r8: assert property (@(posedge clk) disable iff (rst)
        (ctl.rld && !ctl.clr) |=> (cnt_q == $past(load_val)));

    // R4: no request means no change
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clr && !ctl.rld && !ctl.inc) |=> $stable(cnt_q));

    // R1: a plain increment at all ones wraps to zero
    p_wrap_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (ctl.inc && !ctl.clr && !ctl.rld && (&cnt_q)) |=> (cnt_q == '0));

endmodule

// File: rtl/cap_channel.sv
module cap_channel #(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          evt,
    input  logic [CW-1:0] count_i,
    output logic [CW-1:0] hold_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (evt) begin
            hold_q <= count_i;
        end
    end

    // R10: hold gets the count seen before this edge's update
    p_latch_pre_r10: assert property (@(posedge clk) disable iff (rst)
        evt |=> (hold_q == $past(count_i)));

endmodule

// File: rtl/cap_timer.sv
module cap_timer
    import cap_timer_pkg::*;
#(
    parameter  int CW  = 24,
    parameter  int NCH = 3,
    localparam int NF  = NCH + 2,
    localparam int SW  = $clog2(NCH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic [SW-1:0]     src_sel,
    input  logic [NCH-1:0]    cap_in,
    input  logic [NCH-1:0]    edge_evt,
    input  logic              cmp_en,
    input  logic              cmp_clr_en,
    input  logic              cap_clr_en,
    input  logic [NCH-1:0]    clr_src_en,
    input  logic              rld_en,
    input  logic [NCH:0]      rld_src_en,
    input  logic [CW-1:0]     cmp_val,
    input  logic [NF-1:0]     flag_w1c,
    input  logic [NF-1:0]     irq_en,
    output logic [CW-1:0]     count,
    output logic [NCH*CW-1:0] hold_flat,
    output logic [NF-1:0]     flags,
    output logic              irq
);

    localparam int F_CMP = NCH;
    localparam int F_OVF = NCH + 1;

    logic           presc_tick;
    logic [NCH-1:0] src_rise;
    logic           src_tick;
    logic           wrap;
    logic           match;
    logic [CW-1:0]  count_q;
    logic [NF-1:0]  flags_q;
    logic [NF-1:0]  flag_set;
    cnt_ctl_t       ctl;

    cap_prescaler u_presc (
        .clk     (clk),
        .rst     (rst),
        .run_en  (run_en),
        .div_sel (div_sel),
        .tick    (presc_tick)
    );

    cap_src_sync #(.NCH(NCH)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .cap_in (cap_in),
        .rise   (src_rise)
    );

    always_comb begin
        src_tick = (src_sel == '0) ? presc_tick : 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (src_sel == SW'(i + 1)) src_tick = src_rise[i];
        end
    end

    always_comb begin
        ctl.inc = run_en && src_tick;
        wrap    = ctl.inc && (&count_q);
        match   = cmp_en && (count_q == cmp_val);
        ctl.clr = (cap_clr_en && |(edge_evt & clr_src_en)) || (cmp_clr_en && match);
        ctl.rld = rld_en && (|(edge_evt & rld_src_en[NCH-1:0]) || (rld_src_en[NCH] && wrap));
    end

    cap_counter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .load_val (cmp_val),
        .cnt_q    (count_q)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        cap_channel #(.CW(CW)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .evt     (edge_evt[g]),
            .count_i (count_q),
            .hold_q  (hold_flat[g*CW +: CW])
        );
    end

    assign flag_set = {wrap, match, edge_evt};

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~flag_w1c) | flag_set;
        end
    end

    assign count = count_q;
    assign flags = flags_q;
    assign irq   = |(flags_q & irq_en);

    // R11: a flag never drops without its clear strobe
    p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((($past(flags_q) & ~$past(flag_w1c)) & ~flags_q)) == '0));

    // R5: a live match always raises the compare flag
    p_cmp_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (cmp_en && (count_q == cmp_val)) |=> flags_q[F_CMP]);

    // R1: wrapping always raises the overflow flag
    p_ovf_flag_r1: assert property (@(posedge clk) disable iff (rst)
        (run_en && src_tick && (&count_q)) |=> flags_q[F_OVF]);

endmodule

// File: tb/cap_timer_bench.sv
`timescale 1ns/100ps
module cap_timer_bench;

    localparam int          CW   = 24;
    localparam int          NCH  = 3;
    localparam int          NF   = 5;
    localparam logic [23:0] ALL1 = 24'hFFFFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 0, cmp_en = 0, cmp_clr_en = 0, cap_clr_en = 0, rld_en = 0;
    logic [2:0]  div_sel = 0, cap_in = 0, edge_evt = 0, clr_src_en = 0;
    logic [1:0]  src_sel = 0;
    logic [3:0]  rld_src_en = 0;
    logic [23:0] cmp_val = 0;
    logic [4:0]  flag_w1c = 0, irq_en = 0;
    logic [23:0] count;
    logic [71:0] hold_flat;
    logic [4:0]  flags;
    logic        irq;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cap_timer u_cap_timer (
        .clk(clk), .rst(rst), .run_en(run_en), .div_sel(div_sel), .src_sel(src_sel),
        .cap_in(cap_in), .edge_evt(edge_evt), .cmp_en(cmp_en), .cmp_clr_en(cmp_clr_en),
        .cap_clr_en(cap_clr_en), .clr_src_en(clr_src_en), .rld_en(rld_en),
        .rld_src_en(rld_src_en), .cmp_val(cmp_val), .flag_w1c(flag_w1c), .irq_en(irq_en),
        .count(count), .hold_flat(hold_flat), .flags(flags), .irq(irq)
    );

    function automatic int ratio_of(input logic [2:0] c);
        case (c)
            3'd0: return 1;   3'd1: return 4;   3'd2: return 16;  3'd3: return 32;
            3'd4: return 64;  3'd5: return 96;  3'd6: return 112; default: return 128;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Reference model of the requirements, one step per clock edge
    logic [23:0] m_cnt;
    logic [71:0] m_hold;
    logic [4:0]  m_flags;
    logic [2:0]  m_s1, m_s2, m_s3, m_rise;
    int          m_div, m_last;
    logic        m_ptick, m_t, m_inc, m_wrap, m_match, m_clr, m_rld;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_hold = 0; m_flags = 0; m_div = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            m_last  = ratio_of(div_sel) - 1;
            m_ptick = run_en && (m_div >= m_last);
            m_rise  = m_s2 & ~m_s3;
            case (src_sel)
                2'd0: m_t = m_ptick;
                2'd1: m_t = m_rise[0];
                2'd2: m_t = m_rise[1];
                default: m_t = m_rise[2];
            endcase
            m_inc   = run_en && m_t;
            m_wrap  = m_inc && (m_cnt == ALL1);
            m_match = cmp_en && (m_cnt == cmp_val);
            m_clr   = (cap_clr_en && ((edge_evt & clr_src_en) != 0)) || (cmp_clr_en && m_match);
            m_rld   = rld_en && (((edge_evt & rld_src_en[2:0]) != 0) || (rld_src_en[3] && m_wrap));
            for (int i = 0; i < NCH; i++)
                if (edge_evt[i]) m_hold[i*CW +: CW] = m_cnt;
            m_flags = (m_flags & ~flag_w1c) | {m_wrap, m_match, edge_evt};
            if (m_clr)      m_cnt = 0;
            else if (m_rld) m_cnt = cmp_val;
            else if (m_inc) m_cnt = m_cnt + 24'd1;
            if (!run_en)              m_div = 0;
            else if (m_div >= m_last) m_div = 0;
            else                      m_div = m_div + 1;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = cap_in;
        end
    end

    // Model comparison every cycle, half a nanosecond after the edge
    always @(posedge clk) begin
        #0.5;
        if (!rst && !finished) begin
            chk("R1 count vs model", {48'd0, count}, {48'd0, m_cnt});
            chk("R10 hold vs model", hold_flat, m_hold);
            chk("R11 flags vs model", {67'd0, flags}, {67'd0, m_flags});
            chk("R12 irq vs model", {71'd0, irq}, {71'd0, |(m_flags & irq_en)});
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_evt(input logic [2:0] e);
        edge_evt = e;
        cyc(1);
        edge_evt = 0;
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        cyc(3);
        chk("R13 reset count", {48'd0, count}, 72'd0);
        chk("R13 reset hold", hold_flat, 72'd0);
        chk("R13 reset flags/irq", {66'd0, flags, irq}, 72'd0);
        rst = 0;

        // R2: ratio 4, first increment at the 4th edge
        div_sel = 3'd1; run_en = 1;
        cyc(3); chk("R2 div4 before term", {48'd0, count}, 72'd0);
        cyc(1); chk("R2 div4 first tick", {48'd0, count}, 72'd1);
        cyc(4); chk("R2 div4 second tick", {48'd0, count}, 72'd2);
        // R4: halted counter holds
        run_en = 0; div_sel = 3'd5;
        cyc(5); chk("R4 halted hold", {48'd0, count}, 72'd2);
        // R2: ratio 96
        run_en = 1;
        cyc(95); chk("R2 div96 before term", {48'd0, count}, 72'd2);
        cyc(1);  chk("R2 div96 tick", {48'd0, count}, 72'd3);
        run_en = 0; div_sel = 3'd0;

        // R7 clear by enabled channel, R10 hold value and flag
        cap_clr_en = 1; clr_src_en = 3'b010;
        pulse_evt(3'b010);
        chk("R7 clear by ch1", {48'd0, count}, 72'd0);
        chk("R10 hold1 pre-clear", {48'd0, hold_flat[47:24]}, 72'd3);
        chk("R10 flag1 set", {71'd0, flags[1]}, 72'd1);
        flag_w1c = 5'h1F; cyc(1); flag_w1c = 0;
        chk("R11 w1c all", {67'd0, flags}, 72'd0);

        // R5/R6 compare match and restart
        cmp_val = 24'd5; cmp_en = 1; cmp_clr_en = 1; run_en = 1;
        cyc(5); chk("R5 count reaches cmp", {48'd0, count}, 72'd5);
        chk("R5 flag not yet", {71'd0, flags[3]}, 72'd0);
        cyc(1); chk("R6 restart on match", {48'd0, count}, 72'd0);
        chk("R5 cmp flag set", {71'd0, flags[3]}, 72'd1);
        cyc(1); chk("R6 counts after restart", {48'd0, count}, 72'd1);
        run_en = 0; cmp_en = 0; cmp_clr_en = 0;

        // R7 disabled source ignored
        pulse_evt(3'b001);
        chk("R7 ch0 not a clear source", {48'd0, count}, 72'd1);
        chk("R10 hold0", {48'd0, hold_flat[23:0]}, 72'd1);

        // R11 set beats clear
        edge_evt = 3'b001; flag_w1c = 5'b00001; cyc(1); edge_evt = 0; flag_w1c = 0;
        chk("R11 set wins", {71'd0, flags[0]}, 72'd1);
        flag_w1c = 5'b00001; cyc(1); flag_w1c = 0;
        chk("R11 w1c clears", {71'd0, flags[0]}, 72'd0);

        // R12 interrupt masking
        pulse_evt(3'b001);
        irq_en = 5'b00001; cyc(1); chk("R12 irq enabled", {71'd0, irq}, 72'd1);
        irq_en = 5'b00010; cyc(1); chk("R12 irq masked", {71'd0, irq}, 72'd0);
        irq_en = 0; flag_w1c = 5'h1F; cyc(1); flag_w1c = 0;

        // R8 reload by capture, R1 wrap
        cap_clr_en = 0; rld_en = 1; rld_src_en = 4'b0001; cmp_val = 24'hFFFFFE;
        pulse_evt(3'b001);
        chk("R8 reload by ch0", {48'd0, count}, {48'd0, 24'hFFFFFE});
        rld_en = 0; run_en = 1;
        cyc(1); chk("R1 near max", {48'd0, count}, {48'd0, ALL1});
        cyc(1); chk("R1 wrap to zero", {48'd0, count}, 72'd0);
        chk("R1 overflow flag", {71'd0, flags[4]}, 72'd1);
        run_en = 0; rld_en = 1; cmp_val = ALL1;
        pulse_evt(3'b001);
        rld_src_en = 4'b1000; cmp_val = 24'h10; run_en = 1;
        cyc(1); chk("R8 reload on overflow", {48'd0, count}, 72'h10);

        // R9 priorities
        cap_clr_en = 1; clr_src_en = 3'b100; rld_src_en = 4'b0100; cmp_val = 24'h33;
        pulse_evt(3'b100);
        chk("R9 clear beats reload", {48'd0, count}, 72'd0);
        chk("R10 hold2 pre-update", {48'd0, hold_flat[71:48]}, 72'h10);
        cap_clr_en = 0;
        pulse_evt(3'b100);
        chk("R9 reload beats increment", {48'd0, count}, 72'h33);
        run_en = 0; rld_en = 0; rld_src_en = 0;

        // R3 count from synchronized input rise
        src_sel = 2'd1; run_en = 1; cap_in = 3'b001;
        cyc(2); chk("R3 sync delay", {48'd0, count}, 72'h33);
        cyc(1); chk("R3 tick at e+2", {48'd0, count}, 72'h34);
        cyc(3); chk("R3 single tick per rise", {48'd0, count}, 72'h34);
        cap_in = 0; src_sel = 0; run_en = 0;
        flag_w1c = 5'h1F; cyc(1); flag_w1c = 0;

        // Constrained random phase, checked by the model every cycle
        for (int n = 0; n < 4000; n++) begin
            if (n % 64 == 0) begin
                run_en     = ($urandom % 4) != 0;
                div_sel    = ($urandom % 4 == 0) ? 3'($urandom) : 3'd0;
                src_sel    = 2'($urandom);
                cmp_en     = 1'($urandom);
                cmp_clr_en = ($urandom % 3 == 0);
                cap_clr_en = 1'($urandom);
                clr_src_en = 3'($urandom);
                rld_en     = 1'($urandom);
                rld_src_en = 4'($urandom);
                cmp_val    = ($urandom % 8 == 0) ? (ALL1 - 24'($urandom % 40)) : 24'($urandom % 64);
                irq_en     = 5'($urandom);
            end
            edge_evt = ($urandom % 6 == 0) ? 3'($urandom) : 3'd0;
            flag_w1c = ($urandom % 5 == 0) ? 5'($urandom) : 5'd0;
            if ($urandom % 3 == 0) cap_in = cap_in ^ 3'($urandom);
            cyc(1);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule